// File: doc/BRIEF.md
# Shared-Adder Halfband 2x Interpolator Stage

This block doubles the sample rate of a signed audio stream with a halfband FIR filter. Every accepted input sample produces two output samples. The first comes from the filtered polyphase branch: the weighted sum of mirrored pairs of past inputs. The second comes from the centre-tap branch, which is only a delayed copy of the input. The stage gain of two that restores unity overall gain is already folded into the coefficient table. The centre tap (one half times two) therefore passes samples through unchanged.

The block has no hardware multipliers and exactly one adder. A fast system clock steps a sequencer through the work for one sample:
- For each mirrored pair, two reads from a single-port delay-line memory are summed.
- Each nonzero canonic-signed-digit of that pair's coefficient then adds or subtracts a shifted copy of the pair sum into a wide accumulator.

Coefficients are given as a parameter table of signed integers. Their signed-digit form is derived when the design is elaborated. A `busy` flag tells the upstream when the next sample may be offered.

Top module: `hb_interp_stage`

## Requirements
- R1: While `rst` is high and for exactly 2*NPAIR clock cycles after it falls, `busy` is 1 and `out_valid` is 0. During that time the delay line is cleared, so samples before the first accepted one read as zero.
- R2: A sample on `in_data` is accepted at a rising edge where `in_valid` is 1 and `busy` is 0. `busy` is 1 in the following cycle and stays 1 until the sample's processing ends.
- R3: `in_valid` pulses while `busy` is 1 have no effect on any later output value.
- R4: Each accepted sample produces exactly two `out_valid` pulses on consecutive cycles: first `out_phase`=0 (filtered), then `out_phase`=1 (delayed). `busy` is 0 in the cycle of the second pulse.
- R5: With x[n] the newest accepted sample, the filtered output is S = sum over j=0..NPAIR-1 of c_j*(x[n-j] + x[n-(2*NPAIR-1-j)]). Here c_j is the j-th COEF_W-bit signed field of COEFS (field j at bits j*COEF_W upward), weighted 2^-(COEF_W-1). The default table is NPAIR=3, c = {384, -3200, 19200}.
- R6: The filtered output is floor((S + 2^(COEF_W-2)) / 2^(COEF_W-1)), so exact halves round toward plus infinity.
- R7: Both outputs are clipped to the OUT_W-bit signed range: to 2^(OUT_W-1)-1 above it and to -2^(OUT_W-1) below it.
- R8: The delayed output equals x[n-(NPAIR-1)], clipped as in R7.
- R9: With the default table the DC gain is exactly one. Once 2*NPAIR equal samples have been accepted, the filtered output equals that sample value.
- R10: The single shared adder never overflows its signed width while digits are accumulated. Full-scale worst-case inputs therefore still produce correctly clipped outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that sequences the accumulation |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offers `in_data` for acceptance |
| in_data | input | IN_W | Signed input sample at the low rate |
| busy | output | 1 | High while clearing or processing a sample |
| out_valid | output | 1 | One-cycle strobe for each output sample |
| out_phase | output | 1 | 0 = filtered branch, 1 = delayed branch |
| out_data | output | OUT_W | Signed output sample |

## Verification
The stimulus includes:
- Positive and negative single impulses. Each walks through the mirrored tap positions one by one, which exposes a swapped pair, a wrong digit sign or a misplaced read address.
- Small impulses whose products fall exactly on half an output step. These separate round-half-up from truncation and from symmetric rounding.
- A constant run. It confirms unity DC gain once the delay line has filled.
- Full-scale sign patterns aligned with the coefficient signs. These drive the accumulator to its extreme and force clipping in both directions.
- A long pseudo-random stream compared against a direct multiply-and-add model. Every other sample in this stream has junk offered while the block is busy, which shows that such offers leave no trace.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // widest signed-digit vector any coefficient may need
    localparam int CSD_MAXD = 33;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_DIGIT,
        ST_EMIT_F,
        ST_EMIT_D
    } hb_state_e;

    typedef struct packed {
        logic       sub;
        logic [5:0] shift;
    } hb_digit_t;

    // Non-adjacent (canonic) signed-digit recoding. Returns the positions of
    // the +1 digits (want_neg = 0) or of the -1 digits (want_neg = 1).
    function automatic logic [CSD_MAXD-1:0] csd_digits(input longint value, input bit want_neg);
        logic [CSD_MAXD-1:0] r;
        longint x;
        r = '0;
        x = value;
        for (int i = 0; i < CSD_MAXD; i++) begin
            if (x[0]) begin
                if (x[1]) begin
                    r[i] = want_neg;
                    x = x + 1;
                end else begin
                    r[i] = !want_neg;
                    x = x - 1;
                end
            end
            x = x >>> 1;
        end
        return r;
    endfunction

    // index of the lowest set bit, 0 when none is set
    function automatic int low_bit(input logic [CSD_MAXD-1:0] m);
        int k;
        k = 0;
        for (int i = CSD_MAXD - 1; i >= 0; i--) begin
            if (m[i]) k = i;
        end
        return k;
    endfunction

endpackage

// File: rtl/hb_delay_ram.sv
module hb_delay_ram #(
    parameter int W     = 24,
    parameter int DEPTH = 6,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // one port: a cycle either writes or reads the addressed word
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/hb_addsub.sv
module hb_addsub #(
    parameter int W = 46
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);

    // the only adder of the stage; subtraction by inversion and carry-in
    assign sum = a + (sub ? ~b : b) + W'(sub);

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int                      NPAIR  = 3,
    parameter int                      COEF_W = 16,
    parameter logic [NPAIR*COEF_W-1:0] COEFS  = '0,
    parameter int                      DEPTH  = 2 * NPAIR,
    parameter int                      AW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          busy,
    output hb_state_e     state,
    output logic [AW-1:0] addr,
    output logic          we,
    output hb_digit_t     digit
);

    localparam int DIG = COEF_W + 1;
    localparam int PW  = (NPAIR > 1) ? $clog2(NPAIR) : 1;

    logic [DIG-1:0] mask_tab [NPAIR];
    logic [DIG-1:0] neg_tab  [NPAIR];

    for (genvar j = 0; j < NPAIR; j++) begin : g_csd
        localparam longint CJ = longint'($signed(COEFS[j*COEF_W +: COEF_W]));
        localparam logic [CSD_MAXD-1:0] POS_ALL = csd_digits(CJ, 1'b0);
        localparam logic [CSD_MAXD-1:0] NEG_ALL = csd_digits(CJ, 1'b1);
        assign mask_tab[j] = POS_ALL[DIG-1:0] | NEG_ALL[DIG-1:0];
        assign neg_tab[j]  = NEG_ALL[DIG-1:0];
    end

    logic [PW-1:0]  pair;
    logic [AW-1:0]  wp;
    logic [AW-1:0]  clr;
    logic [DIG-1:0] mask;
    int             lsb;
    logic           last_pair;

    // address of the sample k steps older than the newest one
    function automatic logic [AW-1:0] back(input logic [AW-1:0] p, input int k);
        int t;
        t = int'(p) - k;
        if (t < 0) t = t + DEPTH;
        return AW'(t);
    endfunction

    assign lsb       = low_bit(CSD_MAXD'(mask));
    assign last_pair = (int'(pair) == NPAIR - 1);
    assign busy      = (state != ST_IDLE);
    assign we        = (state == ST_CLEAR) || (state == ST_IDLE && in_valid);

    always_comb begin
        digit.shift = 6'(lsb);
        digit.sub   = neg_tab[pair][lsb];
    end

    always_comb begin
        case (state)
            ST_CLEAR:  addr = clr;
            ST_RD_A:   addr = back(wp, int'(pair));
            ST_RD_B:   addr = back(wp, 2 * NPAIR - 1 - int'(pair));
            ST_EMIT_D: addr = back(wp, NPAIR - 1);
            default:   addr = wp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CLEAR;
            clr   <= '0;
            wp    <= '0;
            pair  <= '0;
            mask  <= '0;
        end else begin
            case (state)
                ST_CLEAR: begin
                    if (clr == AW'(DEPTH - 1)) state <= ST_IDLE;
                    else clr <= clr + AW'(1);
                end
                ST_IDLE: begin
                    if (in_valid) begin
                        pair  <= '0;
                        state <= ST_RD_A;
                    end
                end
                ST_RD_A: state <= ST_RD_B;
                ST_RD_B: begin
                    mask <= mask_tab[pair];
                    if (mask_tab[pair] != '0) state <= ST_DIGIT;
                    else if (last_pair) state <= ST_EMIT_F;
                    else begin
                        pair  <= pair + PW'(1);
                        state <= ST_RD_A;
                    end
                end
                ST_DIGIT: begin
                    mask <= mask & (mask - DIG'(1));
                    if ((mask & (mask - DIG'(1))) == '0) begin
                        if (last_pair) state <= ST_EMIT_F;
                        else begin
                            pair  <= pair + PW'(1);
                            state <= ST_RD_A;
                        end
                    end
                end
                ST_EMIT_F: state <= ST_EMIT_D;
                ST_EMIT_D: begin
                    wp    <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) int'(addr) < DEPTH); // R1
    AST_DIGIT_NONEMPTY: assert property (@(posedge clk) disable iff (rst) (state == ST_DIGIT) |-> (mask != '0)); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && in_valid) |=> busy); // R2

endmodule

// File: rtl/hb_interp_stage.sv
module hb_interp_stage
    import hb_pkg::*;
#(
    parameter int                      IN_W   = 24,
    parameter int                      OUT_W  = 24,
    parameter int                      COEF_W = 16,
    parameter int                      NPAIR  = 3,
    parameter logic [NPAIR*COEF_W-1:0] COEFS  = {16'd19200, 16'hF380, 16'd384}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             busy,
    output logic             out_valid,
    output logic             out_phase,
    output logic [OUT_W-1:0] out_data
);

    localparam int DEPTH = 2 * NPAIR;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int DIG   = COEF_W + 1;
    localparam int FRAC  = COEF_W - 1;
    localparam int PS_W  = IN_W + 1;
    localparam int ACC_W = PS_W + DIG + $clog2(NPAIR + 1) + 2;

    localparam logic signed [ACC_W-1:0] ROUND_OFS = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] OMAX      = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] OMIN      = -(ACC_W'(1) << (OUT_W - 1));

    hb_state_e        state;
    hb_digit_t        dig;
    logic [AW-1:0]    addr;
    logic             we;
    logic [IN_W-1:0]  wdata;
    logic [IN_W-1:0]  rdata;

    logic signed [ACC_W-1:0] acc;
    logic signed [PS_W-1:0]  pairsum;
    logic signed [ACC_W-1:0] rd_ext;
    logic signed [ACC_W-1:0] ps_ext;
    logic [ACC_W-1:0]        opa;
    logic [ACC_W-1:0]        opb;
    logic                    op_sub;
    logic [ACC_W-1:0]        sum;

    hb_ctrl #(
        .NPAIR (NPAIR),
        .COEF_W(COEF_W),
        .COEFS (COEFS),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .busy    (busy),
        .state   (state),
        .addr    (addr),
        .we      (we),
        .digit   (dig)
    );

    assign wdata = (state == ST_CLEAR) ? '0 : in_data;

    hb_delay_ram #(
        .W    (IN_W),
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_ram (
        .clk  (clk),
        .we   (we),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata)
    );

    assign rd_ext = ACC_W'($signed(rdata));
    assign ps_ext = ACC_W'(pairsum);

    // the two addend multiplexers in front of the shared adder
    always_comb begin
        case (state)
            ST_RD_A: begin
                opa    = '0;
                opb    = rd_ext;
                op_sub = 1'b0;
            end
            ST_RD_B: begin
                opa    = ps_ext;
                opb    = rd_ext;
                op_sub = 1'b0;
            end
            default: begin
                opa    = acc;
                opb    = ps_ext <<< dig.shift;
                op_sub = dig.sub;
            end
        endcase
    end

    hb_addsub #(.W(ACC_W)) u_add (
        .a  (opa),
        .b  (opb),
        .sub(op_sub),
        .sum(sum)
    );

    function automatic logic [OUT_W-1:0] clip(input logic signed [ACC_W-1:0] v);
        if (v > OMAX) return OMAX[OUT_W-1:0];
        if (v < OMIN) return OMIN[OUT_W-1:0];
        return v[OUT_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            pairsum   <= '0;
            out_valid <= 1'b0;
            out_phase <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                ST_IDLE:  if (in_valid) acc <= ROUND_OFS;
                ST_RD_A,
                ST_RD_B:  pairsum <= sum[PS_W-1:0];
                ST_DIGIT: acc <= sum;
                ST_EMIT_F: begin
                    out_valid <= 1'b1;
                    out_phase <= 1'b0;
                    out_data  <= clip(acc >>> FRAC);
                end
                ST_EMIT_D: begin
                    out_valid <= 1'b1;
                    out_phase <= 1'b1;
                    out_data  <= clip(rd_ext);
                end
                default: ;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIGIT && opa[ACC_W-1] == (opb[ACC_W-1] ^ op_sub)) |-> (sum[ACC_W-1] == opa[ACC_W-1])); // R10
    AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_phase) |=> (out_valid && out_phase)); // R4
    AST_DELAY_FREES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_phase) |-> !busy); // R4
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |-> (busy && !out_valid)); // R1

endmodule

// File: tb/hb_interp_stage_test.sv
module hb_interp_stage_test;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 24;
    localparam int OUT_W = 24;
    localparam int NP    = 3;
    localparam longint C0 = 384;
    localparam longint C1 = -3200;
    localparam longint C2 = 19200;
    localparam longint OMAXV = (64'sd1 <<< (OUT_W - 1)) - 1;
    localparam longint OMINV = -(64'sd1 <<< (OUT_W - 1));

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             busy;
    logic             out_valid;
    logic             out_phase;
    logic [OUT_W-1:0] out_data;

    int     n_chk = 0;
    int     n_bad = 0;
    longint hist [0:511];
    int     nacc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hb_interp_stage uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .busy     (busy),
        .out_valid(out_valid),
        .out_phase(out_phase),
        .out_data (out_data)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint xat(input int k);
        if (nacc - 1 - k < 0) return 0;
        return hist[nacc - 1 - k];
    endfunction

    function automatic longint sat(input longint v);
        if (v > OMAXV) return OMAXV;
        if (v < OMINV) return OMINV;
        return v;
    endfunction

    function automatic longint gold_filt();
        longint s;
        s = C0 * (xat(0) + xat(5)) + C1 * (xat(1) + xat(4)) + C2 * (xat(2) + xat(3));
        return sat((s + 16384) >>> 15);
    endfunction

    // offers one sample, optionally pokes junk while busy, checks both outputs
    task automatic send(input longint v, input bit poke, input string tag, output longint filt);
        int guard;
        longint act;
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b1;
        in_data  = v[IN_W-1:0];
        @(negedge clk);
        hist[nacc] = longint'($signed(v[IN_W-1:0]));
        nacc++;
        if (poke) in_data = ~in_data ^ 24'h5A5A5A;
        else in_valid = 1'b0;
        check("R2 busy after accept", longint'(busy), 1);
        guard = 0;
        while (!out_valid && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b0;
        check("R4 first phase", longint'(out_phase), 0);
        act  = longint'($signed(out_data));
        filt = act;
        check(poke ? "R3 filtered after junk" : tag, act, gold_filt());
        @(negedge clk);
        check("R4 second valid", longint'(out_valid), 1);
        check("R4 second phase", longint'(out_phase), 1);
        check("R4 busy low at second", longint'(busy), 0);
        check(poke ? "R3 delayed after junk" : "R8 delayed", longint'($signed(out_data)), sat(xat(NP - 1)));
        @(negedge clk);
        check("R4 no third output", longint'(out_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint f;
        longint m;
        int n;
        int unsigned lfsr;

        repeat (3) @(negedge clk);
        check("R1 busy in reset", longint'(busy), 1);
        check("R1 valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            @(posedge clk);
            #1;
            check("R1 no output while clearing", longint'(out_valid), 0);
            n++;
        end
        check("R1 clear length", n, 2 * NP);
        @(negedge clk);

        // impulses walk each coefficient across the mirrored positions
        send(64'sd1 <<< 20, 1'b0, "R1 R5 impulse", f);
        for (int i = 0; i < 6; i++) send(0, 1'b0, "R5 impulse tail", f);
        send(-(64'sd1 <<< 20), 1'b0, "R5 negative impulse", f);
        for (int i = 0; i < 6; i++) send(0, 1'b0, "R5 negative tail", f);

        // exact half steps: +1.5 -> 2, -1.5 -> -1, -12.5 -> -12
        send(128, 1'b0, "R6 half rounding", f);
        check("R6 +1.5 rounds up", f, 2);
        send(0, 1'b0, "R6 half rounding", f);
        check("R6 -12.5 rounds up", f, -12);
        for (int i = 0; i < 5; i++) send(0, 1'b0, "R6 tail", f);
        send(-128, 1'b0, "R6 half rounding", f);
        check("R6 -1.5 rounds up", f, -1);
        for (int i = 0; i < 6; i++) send(0, 1'b0, "R6 tail", f);

        // constant run
        for (int i = 0; i < 8; i++) begin
            send(1000000, 1'b0, "R9 dc", f);
            if (i >= 5) check("R9 unity dc gain", f, 1000000);
        end

        // full-scale sign patterns aligned with coefficient signs
        m = OMAXV;
        send(m, 1'b0, "R7 R10 fullscale", f);
        send(-m, 1'b0, "R7 R10 fullscale", f);
        send(m, 1'b0, "R7 R10 fullscale", f);
        send(m, 1'b0, "R7 R10 fullscale", f);
        send(-m, 1'b0, "R7 R10 fullscale", f);
        send(m, 1'b0, "R7 R10 fullscale", f);
        check("R7 positive clip", f, OMAXV);
        m = OMINV;
        send(m, 1'b0, "R7 R10 fullscale", f);
        send(-m - 1, 1'b0, "R7 R10 fullscale", f);
        send(m, 1'b0, "R7 R10 fullscale", f);
        send(m, 1'b0, "R7 R10 fullscale", f);
        send(-m - 1, 1'b0, "R7 R10 fullscale", f);
        send(m, 1'b0, "R7 R10 fullscale", f);
        check("R7 negative clip", f, OMINV);

        // pseudo-random stream, junk offered while busy on every other sample
        lfsr = 32'h1234_5678;
        for (int i = 0; i < 80; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            send(longint'($signed(lfsr[IN_W-1:0])), i[0], "R5 R10 random", f);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule